// File: doc/BRIEF.md
# Serial Switch Register Access Master

This block lets on-chip logic read and write the 16-bit configuration registers of an Ethernet switch over a three-wire serial link shaped like a serial EEPROM port. The wires are a chip select, a serial clock and one data line. The master drives the data line during command bits and releases it so the switch can answer. A request carries a direction, an address and write data. When the block has finished, it raises a one-cycle done pulse and, for a read, presents the selected register value.

Reads and writes use different frames. A read keeps chip select low. It sends a long run of ones followed by a short command word and a 7-bit address. It then releases the line for two idle clocks and clocks in 32 bits, which are two adjacent registers; the low address bit picks the half to keep. A write raises chip select and sends a 27-bit frame made of a start bit, an opcode, an 8-bit address and 16 data bits. Chip select then drops. Both kinds of frame close with two extra clock pulses, and the clock is left low.

All serial timing is counted in ticks of a divider that runs from the system clock. Low phases, high phases, data setup and chip-select setup last a parameterised number of ticks. This lets the same block meet microsecond-scale minimums on silicon and run fast in a bench. The request side is a valid/ready handshake: a request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. While `req_ready` is low, the requester may hold, change or drop `req_valid`, and the block ignores it. The response side has no back-pressure: `rsp_done` is a single-cycle pulse.

Top module: `swreg_serial_master`

## Requirements
- R1: A read sends 46 bits MSB first: 32 ones, then the bits 0,1,1,0,0,0,0, then address bits 6 down to 0. `sw_cs` stays 0 for the whole read.
- R2: After the last read command bit, the data line is released (`sw_doe`=0). Exactly 2 clock rises pass before the first read-data bit is sampled.
- R3: Read data is 32 bits, MSB first. Each bit is sampled at the end of the clock-low phase, just before its rising edge.
- R4: When a read finishes, `rsp_rdata` holds the first 16 bits received if `req_addr[0]`=1, and the last 16 bits received if `req_addr[0]`=0.
- R5: A write sends 27 bits MSB first: the bits 1,0,1, then `req_addr[7:0]`, then `req_wdata[15:0]`. `sw_cs`=1 at all 27 of those rises, and `sw_cs` is 0 before the first trailing clock.
- R6: Every transaction ends with exactly 2 trailing clock pulses after its last data bit, and `sw_sck` returns to 0.
- R7: Every clock-low phase and every clock-high phase lasts at least EDGE_TICKS ticks. Each driven bit is stable for at least SETUP_TICKS ticks before its rising edge.
- R8: `sw_cs` takes its frame level at acceptance and holds it for at least EDGE_TICKS ticks before the first clock rise.
- R9: `sw_doe` is 1 only while command or write bits are being driven. It rises once per transaction and is 0 during turnaround, read data, trailing clocks and idle.
- R10: A request is accepted only when `req_ready`=1. `req_valid` while busy is ignored. `rsp_done` is a one-cycle pulse with `req_ready` already 1. `rsp_rdata` changes only with `rsp_done` and is unchanged by a write.
- R11: Reset (asynchronous, active low) forces `sw_cs`=0, `sw_sck`=0, `sw_doe`=0, `rsp_done`=0, `rsp_rdata`=0 and `req_ready`=1, even in the middle of a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address (reads use bits 6:0) |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Selected read data, held until the next read completes |
| sw_cs | output | 1 | Serial chip select |
| sw_sck | output | 1 | Serial clock |
| sw_dout | output | 1 | Serial data driven by the master |
| sw_doe | output | 1 | Output enable for the data line |
| sw_din | input | 1 | Serial data from the switch |

## Verification
The assertions assume that `rst_n` is the only way the sequence is aborted and that the divider settings are nonzero. They also assume that `sw_din` matters only in the read-data phase, so they say nothing about its value elsewhere. The stimulus drives every request and the reset from the falling clock edge. The responder changes `sw_din` only in the cycle after the serial clock has fallen, so a data bit never moves near the sampling point. The stimulus also drives spurious `req_valid` pulses while the block is busy, to confirm that they are dropped.

// File: rtl/swreg_pkg.sv
package swreg_pkg;
  localparam int REG_W     = 16;
  localparam int ADDR_W    = 8;
  localparam int RD_ADDR_W = 7;
  localparam int RD_PRE_W  = 32;
  localparam int RD_CMD_W  = RD_PRE_W + 7 + RD_ADDR_W;
  localparam int WR_CMD_W  = 3 + ADDR_W + REG_W;
  localparam int RD_WORD_W = 2 * REG_W;
  localparam int SHIFT_W   = RD_CMD_W;
  localparam int CNT_W     = $clog2(SHIFT_W + 1);
  localparam int EXTRA_CLKS = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CSH, ST_LOW, ST_SETUP, ST_HIGH, ST_TAIL, ST_XHIGH, ST_XLOW
  } seq_state_e;

  typedef enum logic [1:0] {
    SEG_CMD, SEG_TURN, SEG_RDAT, SEG_TRAIL
  } seg_e;
endpackage

// File: rtl/swreg_tick_div.sv
module swreg_tick_div #(
  parameter int CLK_DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  generate
    if (CLK_DIV > 1) begin : g_chk
      // R7: ticks are spaced, so phase lengths scale with the divider
      p_tick_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/swreg_frame_build.sv
module swreg_frame_build
  import swreg_pkg::*;
(
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [SHIFT_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  localparam int PAD_W = SHIFT_W - WR_CMD_W;

  always_comb begin
    if (is_write) begin
      frame = {3'b101, addr, wdata, {PAD_W{1'b0}}};
      nbits = CNT_W'(WR_CMD_W);
    end else begin
      frame = {{RD_PRE_W{1'b1}}, 7'b0110000, addr[RD_ADDR_W-1:0]};
      nbits = CNT_W'(RD_CMD_W);
    end
  end
endmodule

// File: rtl/swreg_seq.sv
module swreg_seq
  import swreg_pkg::*;
#(
  parameter int EDGE_TICKS  = 3,
  parameter int SETUP_TICKS = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_lsb,
  input  logic [SHIFT_W-1:0] frame,
  input  logic [CNT_W-1:0]   nbits,
  output logic               req_ready,
  output logic               rsp_done,
  output logic [REG_W-1:0]   rsp_rdata,
  output logic               sw_cs,
  output logic               sw_sck,
  output logic               sw_dout,
  output logic               sw_doe,
  input  logic               sw_din
);
  localparam int WMAX = (EDGE_TICKS > SETUP_TICKS) ? EDGE_TICKS : SETUP_TICKS;
  localparam int WCW  = $clog2(WMAX + 2);
  localparam logic [WCW-1:0] W_EDGE  = WCW'(EDGE_TICKS);
  localparam logic [WCW-1:0] W_SETUP = WCW'(SETUP_TICKS);

  seq_state_e         state;
  seg_e               seg;
  logic               is_wr;
  logic               lsb;
  logic [SHIFT_W-1:0] shreg;
  logic [CNT_W-1:0]   bits_left;
  logic [1:0]         pulses;
  logic [WCW-1:0]     wcnt;
  logic [RD_WORD_W-1:0] rd_sh;
  logic               wdone;

  assign req_ready = (state == ST_IDLE);
  assign wdone     = tick && (wcnt <= WCW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      seg       <= SEG_CMD;
      is_wr     <= 1'b0;
      lsb       <= 1'b0;
      shreg     <= '0;
      bits_left <= '0;
      pulses    <= '0;
      wcnt      <= '0;
      rd_sh     <= '0;
      sw_cs     <= 1'b0;
      sw_sck    <= 1'b0;
      sw_dout   <= 1'b0;
      sw_doe    <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      if (state != ST_IDLE && tick && wcnt > WCW'(1)) wcnt <= wcnt - 1'b1;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            shreg     <= frame;
            bits_left <= nbits;
            is_wr     <= req_write;
            lsb       <= req_lsb;
            sw_cs     <= req_write;
            seg       <= SEG_CMD;
            wcnt      <= W_EDGE;
            state     <= ST_CSH;
          end
        end
        ST_CSH: if (wdone) begin
          sw_sck <= 1'b0;
          wcnt   <= W_EDGE;
          state  <= ST_LOW;
        end
        ST_LOW: if (wdone) begin
          if (seg == SEG_CMD) begin
            sw_dout <= shreg[SHIFT_W-1];
            shreg   <= {shreg[SHIFT_W-2:0], 1'b0};
            sw_doe  <= 1'b1;
            wcnt    <= W_SETUP;
            state   <= ST_SETUP;
          end else begin
            rd_sh  <= {rd_sh[RD_WORD_W-2:0], sw_din};
            sw_sck <= 1'b1;
            wcnt   <= W_EDGE;
            state  <= ST_HIGH;
          end
        end
        ST_SETUP: if (wdone) begin
          sw_sck <= 1'b1;
          wcnt   <= W_EDGE;
          state  <= ST_HIGH;
        end
        ST_HIGH: if (wdone) begin
          sw_sck    <= 1'b0;
          wcnt      <= W_EDGE;
          bits_left <= bits_left - 1'b1;
          state     <= (bits_left > CNT_W'(1)) ? ST_LOW : ST_TAIL;
        end
        ST_TAIL: if (wdone) begin
          sw_doe <= 1'b0;
          pulses <= 2'(EXTRA_CLKS);
          sw_sck <= 1'b1;
          wcnt   <= W_EDGE;
          state  <= ST_XHIGH;
          if (seg == SEG_CMD && !is_wr) begin
            seg <= SEG_TURN;
          end else begin
            seg   <= SEG_TRAIL;
            sw_cs <= 1'b0;
          end
        end
        ST_XHIGH: if (wdone) begin
          sw_sck <= 1'b0;
          wcnt   <= W_EDGE;
          state  <= ST_XLOW;
        end
        ST_XLOW: if (wdone) begin
          if (pulses > 2'd1) begin
            pulses <= pulses - 1'b1;
            sw_sck <= 1'b1;
            wcnt   <= W_EDGE;
            state  <= ST_XHIGH;
          end else if (seg == SEG_TURN) begin
            seg       <= SEG_RDAT;
            bits_left <= CNT_W'(RD_WORD_W);
            wcnt      <= W_EDGE;
            state     <= ST_CSH;
          end else begin
            state    <= ST_IDLE;
            rsp_done <= 1'b1;
            sw_dout  <= 1'b0;
            if (!is_wr)
              rsp_rdata <= lsb ? rd_sh[RD_WORD_W-1:REG_W] : rd_sh[REG_W-1:0];
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: chip select never rises during a read
  p_read_cs_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !is_wr) |-> !sw_cs);
  // R9: line driven only in the command segment
  p_doe_cmd_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_doe |-> (seg == SEG_CMD && !req_ready));
  // R6: clock parked low and line released while idle
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!sw_sck && !sw_doe));
  // R7: clock edges only follow a tick
  p_edge_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_sck) |-> $past(tick));
  // R7: data never moves with a rising clock
  p_dout_stable_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_sck) |-> $stable(sw_dout));
  // R10: done is a single pulse and the block is idle with it
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);
  // R10: read data moves only on completion
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_rdata) |-> rsp_done);
endmodule

// File: rtl/swreg_serial_master.sv
module swreg_serial_master
  import swreg_pkg::*;
#(
  parameter int CLK_DIV     = 50,
  parameter int EDGE_TICKS  = 3,
  parameter int SETUP_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  output logic              rsp_done,
  output logic [REG_W-1:0]  rsp_rdata,
  output logic              sw_cs,
  output logic              sw_sck,
  output logic              sw_dout,
  output logic              sw_doe,
  input  logic              sw_din
);
  logic               tick;
  logic [SHIFT_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  swreg_tick_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (!req_ready),
    .tick (tick)
  );

  swreg_frame_build u_frame (
    .is_write(req_write),
    .addr    (req_addr),
    .wdata   (req_wdata),
    .frame   (frame),
    .nbits   (nbits)
  );

  swreg_seq #(.EDGE_TICKS(EDGE_TICKS), .SETUP_TICKS(SETUP_TICKS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_lsb  (req_addr[0]),
    .frame    (frame),
    .nbits    (nbits),
    .req_ready(req_ready),
    .rsp_done (rsp_done),
    .rsp_rdata(rsp_rdata),
    .sw_cs    (sw_cs),
    .sw_sck   (sw_sck),
    .sw_dout  (sw_dout),
    .sw_doe   (sw_doe),
    .sw_din   (sw_din)
  );

  // R11: outputs quiet during reset recovery window
  p_reset_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sw_cs && !sw_sck && !sw_doe));
endmodule

// File: tb/swreg_serial_master_test.sv
module swreg_serial_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;
  localparam int EDGE = 3;
  localparam int SETUP = 1;
  localparam int MAX_CYC = 150000;
  localparam int NVEC = 8;
  // {write, addr, wdata, responder word, expected rdata}
  localparam logic [72:0] VEC [NVEC] = '{
    {1'b0, 8'h01, 16'h0000, 32'hA5C3_0F1E, 16'hA5C3},
    {1'b0, 8'h02, 16'h0000, 32'h1234_BEEF, 16'hBEEF},
    {1'b1, 8'hC5, 16'h9A6B, 32'h0000_0000, 16'hBEEF},
    {1'b0, 8'h7F, 16'h0000, 32'hFFFF_0000, 16'hFFFF},
    {1'b0, 8'h00, 16'h0000, 32'h8001_7FFE, 16'h7FFE},
    {1'b1, 8'h00, 16'hFFFF, 32'h0000_0000, 16'h7FFE},
    {1'b1, 8'hFF, 16'h0001, 32'h0000_0000, 16'h7FFE},
    {1'b0, 8'h40, 16'h0000, 32'h5555_AAAA, 16'hAAAA}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, sw_din = 1'b0;
  logic [7:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_done, sw_cs, sw_sck, sw_dout, sw_doe;
  logic [15:0] rsp_rdata;

  int total = 0, bad = 0, cyc = 0;
  // monitor state
  logic [45:0] cap;
  int rises, cmd_bits, pc_rises, cs_cmd_hi, cs_trail_hi, doe_rises, dones;
  int timing_bad, last_fall, last_rise, last_dchg, t_cs, t_first;
  logic prev_sck = 0, prev_dout = 0, prev_doe = 0, prev_cs = 0;
  logic [31:0] rsp_word;
  logic rd_txn;

  swreg_serial_master #(.CLK_DIV(DIV), .EDGE_TICKS(EDGE), .SETUP_TICKS(SETUP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .sw_cs(sw_cs), .sw_sck(sw_sck),
    .sw_dout(sw_dout), .sw_doe(sw_doe), .sw_din(sw_din));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic clear_mon();
    cap = '0; rises = 0; cmd_bits = 0; pc_rises = 0; cs_cmd_hi = 0; cs_trail_hi = 0;
    doe_rises = 0; dones = 0; timing_bad = 0; last_fall = cyc; last_rise = cyc;
    last_dchg = cyc; t_cs = cyc; t_first = -1;
  endtask

  // monitor and responder, sampled on the falling clock edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > MAX_CYC) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, MAX_CYC);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (sw_dout != prev_dout) last_dchg = cyc;
    if (sw_cs && !prev_cs) t_cs = cyc;
    if (sw_doe && !prev_doe) doe_rises++;
    if (rsp_done) dones++;
    if (sw_sck && !prev_sck) begin
      if (t_first < 0) t_first = cyc;
      if (cyc - last_fall < EDGE*DIV) timing_bad++;
      rises++;
      last_rise = cyc;
      if (sw_doe) begin
        if (cyc - last_dchg < SETUP*DIV) timing_bad++;
        cap = {cap[44:0], sw_dout};
        cmd_bits++;
        if (sw_cs) cs_cmd_hi++;
      end else begin
        pc_rises++;
        if (sw_cs) cs_trail_hi++;
      end
    end
    if (!sw_sck && prev_sck) begin
      if (cyc - last_rise < EDGE*DIV) timing_bad++;
      last_fall = cyc;
      if (rd_txn && pc_rises >= 2 && pc_rises < 34) sw_din = rsp_word[31-(pc_rises-2)];
    end
    prev_sck = sw_sck; prev_dout = sw_dout; prev_doe = sw_doe; prev_cs = sw_cs;
  end

  task automatic run_txn(input logic wr, input logic [7:0] a, input logic [15:0] wd,
                         input logic [31:0] word, input logic [15:0] exp, input logic poke);
    int guard;
    @(negedge clk);
    #1;
    clear_mon();
    rsp_word = word; rd_txn = !wr;
    chk(req_ready, "R10 ready before request", req_ready, 1);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    #1;
    req_valid = 0;
    chk(!req_ready, "R10 busy after accept", req_ready, 0);
    guard = 0;
    while (!rsp_done && guard < 5000) begin
      @(negedge clk);
      #1;
      guard++;
      if (poke && guard >= 20 && guard < 25) begin
        req_valid = 1; req_write = !wr; req_addr = ~a; req_wdata = ~wd;
      end else req_valid = 0;
    end
    req_valid = 0;
    chk(guard < 5000, "R10 done arrives", guard, 5000);
    chk(req_ready, "R10 ready with done", req_ready, 1);
    chk(rsp_rdata == exp, "R4 R10 read data", rsp_rdata, exp);
    @(negedge clk);
    #1;
    chk(!rsp_done, "R10 done one cycle", rsp_done, 0);
    chk(dones == 1, "R10 single completion", dones, 1);
    chk(!sw_sck && !sw_doe, "R6 clock low line released", {sw_sck, sw_doe}, 0);
    chk(timing_bad == 0, "R7 phase and setup timing", timing_bad, 0);
    chk(doe_rises == 1, "R9 enable once", doe_rises, 1);
    if (!wr) begin
      chk(cmd_bits == 46, "R1 read command length", cmd_bits, 46);
      chk(cap == {32'hFFFF_FFFF, 7'b0110000, a[6:0]}, "R1 read frame", cap,
          {32'hFFFF_FFFF, 7'b0110000, a[6:0]});
      chk(cs_cmd_hi == 0 && cs_trail_hi == 0, "R1 cs low in read", cs_cmd_hi + cs_trail_hi, 0);
      chk(pc_rises == 36, "R2 R3 R6 turn data trail rises", pc_rises, 36);
      chk(rises == 82, "R6 read total rises", rises, 82);
      chk(t_first - (cyc - guard - 2) >= EDGE*DIV, "R8 setup before first rise",
          t_first, EDGE*DIV);
    end else begin
      chk(cmd_bits == 27, "R5 write length", cmd_bits, 27);
      chk(cap[26:0] == {3'b101, a, wd}, "R5 write frame", cap[26:0], {3'b101, a, wd});
      chk(cs_cmd_hi == 27, "R5 cs high on bits", cs_cmd_hi, 27);
      chk(cs_trail_hi == 0, "R5 cs dropped before trail", cs_trail_hi, 0);
      chk(pc_rises == 2, "R6 write trailing clocks", pc_rises, 2);
      chk(t_first - t_cs >= EDGE*DIV, "R8 cs setup", t_first - t_cs, EDGE*DIV);
    end
  endtask

  initial begin
    rd_txn = 0; rsp_word = '0;
    clear_mon();
    repeat (3) @(negedge clk);
    #1;
    chk(!sw_cs && !sw_sck && !sw_doe && !rsp_done && req_ready && rsp_rdata == 0,
        "R11 reset state", {sw_cs, sw_sck, sw_doe, rsp_done, req_ready}, 5'b00001);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // vector table walk
    for (int i = 0; i < NVEC; i++)
      run_txn(VEC[i][72], VEC[i][71:64], VEC[i][63:48], VEC[i][47:16], VEC[i][15:0], 1'b0);
    // R10: spurious valid during a busy read and a busy write
    run_txn(1'b0, 8'h33, 16'h0, 32'hC0DE_1357, 16'hC0DE, 1'b1);
    run_txn(1'b1, 8'h5A, 16'h2468, 32'h0, 16'hC0DE, 1'b1);
    // R11: reset in the middle of a read
    @(negedge clk);
    #1;
    req_valid = 1; req_write = 0; req_addr = 8'h11; rd_txn = 1;
    @(negedge clk);
    #1;
    req_valid = 0;
    repeat (150) @(negedge clk);
    #1;
    rst_n = 0;
    @(negedge clk);
    #1;
    chk(!sw_cs && !sw_sck && !sw_doe && req_ready && rsp_rdata == 0,
        "R11 mid-transaction reset", {sw_cs, sw_sck, sw_doe, req_ready}, 4'b0001);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_txn(1'b0, 8'h06, 16'h0, 32'h0F0F_F00F, 16'hF00F, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule